// File: doc/BRIEF.md
# Issue-Stepped Exposed Arithmetic Pipeline

This block is an integer arithmetic pipeline whose stages move forward only when an operation is accepted on its issue port. The clock alone never moves it. Each accepted issue carries an opcode, two operands and a register index. The index is not the destination of the operation being started. It names the register that receives the result leaving the last stage on that same step. Software therefore sees the latency directly: results come out only as later issues push them along. A no-op issue exists to drain the pipeline.

There are two latency classes. The short class covers add and single-width multiply, which take three stages. The long class is a double-width multiply, which takes two stages, and each of its steps occupies two clocks. Classes are never mixed in flight. An opcode from the other class is refused until every stage is empty.

The issue port follows valid/ready rules. An issue is accepted on a rising edge where both `issue_valid` and `issue_ready` are high. `issue_ready` may depend on the offered `issue_op`. While ready is low, the producer holds its request, and nothing in the pipeline moves. The write port has no back-pressure.

Top module: `issue_step_pipe`

## Requirements
- R1: Synchronous active-high reset clears every in-flight valid bit, the busy state and `wr_en`. On the first cycle after reset, `issue_ready` is high for any opcode.
- R2: Without an accepted issue, no stage moves and `wr_en` stays low. Held results come out unchanged on later issues, however many idle cycles pass in between.
- R3: A short-class operation accepted as issue number k is written on issue number k+3. The index used is the `issue_dest` of issue k+3.
- R4: Opcodes are 0 no-op, 1 add, 2 multiply-low and 3 wide multiply. Add writes the low W bits of a+b, zero-extended to 2W. Multiply-low writes the low W bits of a*b, zero-extended to 2W. Wide multiply writes the full 2W-bit product.
- R5: A wide multiply accepted as issue k is written on issue k+2, with the `issue_dest` of issue k+2.
- R6: After any issue accepted while the long class is active, `issue_ready` is low for exactly the next cycle. Throughput is therefore at most one result every two clocks.
- R7: While any stage holds a valid operation, a non-no-op opcode of the other class sees `issue_ready` low. A no-op is always class-compatible.
- R8: An issue whose exiting slot holds no valid operation produces no write, even though a destination index was supplied.
- R9: `wr_en` is high for exactly one clock per retiring valid result. That clock is the one after the accepting edge, and `wr_idx` and `wr_data` are valid during it.
- R10: An issue offered while `issue_ready` is low is not accepted. It moves no stage and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue request |
| issue_ready | output | 1 | Issue can be accepted for the offered opcode |
| issue_op | input | 2 | Opcode (0 no-op, 1 add, 2 mul-low, 3 wide mul) |
| issue_a | input | W | First operand |
| issue_b | input | W | Second operand |
| issue_dest | input | IW | Register index for the result exiting on this issue |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | IW | Register write index |
| wr_data | output | 2W | Register write data |

## Verification
The assertions assume that reset is asserted at the first clock edge. They also assume that `issue_op` holds a defined value whenever `issue_valid` is high, because the ready checks look at the offered opcode. The stimulus meets both conditions: it holds reset from time zero, and it always drives every issue field from two-bit and W-bit random values, including on cycles where valid is low. Random opcode mixes cause frequent class conflicts and long-class stall cycles. Directed sequences cover idle holds, draining with no-ops and class switching.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_ADD  = 2'd1,
    OP_MUL  = 2'd2,
    OP_WMUL = 2'd3
  } op_e;

  function automatic logic op_is_long(op_e op);
    return op == OP_WMUL;
  endfunction
endpackage

// File: rtl/isp_alu.sv
module isp_alu
  import isp_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e              op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [2*W-1:0]   res
);
  localparam int DW = 2 * W;

  logic [DW-1:0] prod;
  logic [W-1:0]  sum;

  always_comb begin
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    sum  = a + b;
    unique case (op)
      OP_ADD:  res = {{W{1'b0}}, sum};
      OP_MUL:  res = {{W{1'b0}}, prod[W-1:0]};
      OP_WMUL: res = prod;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/isp_slot.sv
module isp_slot #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          in_v,
  input  logic [PW-1:0] in_p,
  output logic          out_v,
  output logic [PW-1:0] out_p
);
  always_ff @(posedge clk) begin
    if (rst)      out_v <= 1'b0;
    else if (adv) out_v <= in_v;
  end

  // payload is not reset; the valid bit alone qualifies it
  always_ff @(posedge clk) begin
    if (adv) out_p <= in_p;
  end
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
  import isp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic issue_valid,
  input  op_e  issue_op,
  input  logic any_live,
  output logic issue_ready,
  output logic fire,
  output logic mode_long,
  output logic mode_long_next
);
  logic busy_q;
  logic compat;

  always_comb begin
    compat = !any_live || (issue_op == OP_NOP) ||
             (op_is_long(issue_op) == mode_long);
    issue_ready    = !busy_q && compat;
    fire           = issue_valid && issue_ready;
    mode_long_next = (issue_op != OP_NOP) ? op_is_long(issue_op) : mode_long;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      mode_long <= 1'b0;
    end else begin
      // each long-class step holds the port for one extra clock
      busy_q <= fire && mode_long_next;
      if (fire) mode_long <= mode_long_next;
    end
  end
endmodule

// File: rtl/issue_step_pipe.sv
module issue_step_pipe
  import isp_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  output logic            issue_ready,
  input  logic [1:0]      issue_op,
  input  logic [W-1:0]    issue_a,
  input  logic [W-1:0]    issue_b,
  input  logic [IW-1:0]   issue_dest,
  output logic            wr_en,
  output logic [IW-1:0]   wr_idx,
  output logic [2*W-1:0]  wr_data
);
  localparam int DW   = 2 * W;
  localparam int OPW  = 2;
  localparam int P0W  = OPW + 2 * W;
  localparam int LAST = 2;

  op_e           op_in;
  logic          fire, mode_long, mode_long_next, any_live;

  logic          v0;
  logic [P0W-1:0] p0;
  op_e           op0;
  logic [W-1:0]  a0, b0;
  logic [DW-1:0] res0;

  logic          vs [1:LAST];
  logic [DW-1:0] rs [1:LAST];

  logic          exit_v;
  logic [DW-1:0] exit_res;

  assign op_in = op_e'(issue_op);

  isp_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .issue_valid    (issue_valid),
    .issue_op       (op_in),
    .any_live       (any_live),
    .issue_ready    (issue_ready),
    .fire           (fire),
    .mode_long      (mode_long),
    .mode_long_next (mode_long_next)
  );

  // entry stage: captures opcode and operands
  isp_slot #(.PW(P0W)) u_slot0 (
    .clk   (clk),
    .rst   (rst),
    .adv   (fire),
    .in_v  (op_in != OP_NOP),
    .in_p  ({issue_op, issue_a, issue_b}),
    .out_v (v0),
    .out_p (p0)
  );

  assign op0 = op_e'(p0[P0W-1 -: OPW]);
  assign a0  = p0[2*W-1:W];
  assign b0  = p0[W-1:0];

  isp_alu #(.W(W)) u_alu (
    .op  (op0),
    .a   (a0),
    .b   (b0),
    .res (res0)
  );

  // result stages; the last one is unused by the long class
  for (genvar g = 1; g <= LAST; g++) begin : g_res
    logic          in_v;
    logic [DW-1:0] in_p;
    if (g == 1) begin : g_first
      assign in_v = v0;
      assign in_p = res0;
    end else begin : g_next
      assign in_v = vs[g-1] && !mode_long_next;
      assign in_p = rs[g-1];
    end
    isp_slot #(.PW(DW)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .adv   (fire),
      .in_v  (in_v),
      .in_p  (in_p),
      .out_v (vs[g]),
      .out_p (rs[g])
    );
  end

  assign any_live = v0 || vs[1] || vs[2];

  always_comb begin
    if (mode_long) begin
      exit_v   = vs[1];
      exit_res = rs[1];
    end else begin
      exit_v   = vs[LAST];
      exit_res = rs[LAST];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_en <= 1'b0;
    else     wr_en <= fire && exit_v;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      wr_idx  <= issue_dest;
      wr_data <= exit_res;
    end
  end
endmodule

// File: rtl/isp_checker.sv
module isp_checker (
  input logic       clk,
  input logic       rst,
  input logic       issue_valid,
  input logic       issue_ready,
  input logic [1:0] issue_op,
  input logic       wr_en,
  input logic       any_live,
  input logic       mode_long
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!wr_en && issue_ready));

  assert_no_write_without_issue_R2: assert property (@(posedge clk) disable iff (rst)
    !(issue_valid && issue_ready) |=> !wr_en);

  assert_long_step_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_ready && issue_op == 2'd3) |=> !issue_ready);

  assert_class_refused_R7: assert property (@(posedge clk) disable iff (rst)
    (any_live && issue_op != 2'd0 && (mode_long != (issue_op == 2'd3))) |-> !issue_ready);
endmodule

bind issue_step_pipe isp_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_op    (issue_op),
  .wr_en       (wr_en),
  .any_live    (any_live),
  .mode_long   (mode_long)
);

// File: tb/issue_step_pipe_test.sv
module issue_step_pipe_test;
  localparam int W  = 16;
  localparam int IW = 5;
  localparam int DW = 2 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          issue_valid = 1'b0;
  logic          issue_ready;
  logic [1:0]    issue_op = 2'd0;
  logic [W-1:0]  issue_a = '0, issue_b = '0;
  logic [IW-1:0] issue_dest = '0;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;

  issue_step_pipe #(.W(W), .IW(IW)) uut (
    .clk (clk), .rst (rst),
    .issue_valid (issue_valid), .issue_ready (issue_ready),
    .issue_op (issue_op), .issue_a (issue_a), .issue_b (issue_b),
    .issue_dest (issue_dest),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  bit            mv [3];
  logic [DW-1:0] mr [3];
  bit            mlong, mbusy;
  bit            exp_we = 1'b0;
  bit            exp_long = 1'b0;
  logic [IW-1:0] exp_idx;
  logic [DW-1:0] exp_dat;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_res(logic [1:0] op, logic [W-1:0] x, logic [W-1:0] y);
    logic [DW-1:0] p;
    logic [W-1:0]  s;
    p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    s = x + y;
    case (op)
      2'd1:    return {{W{1'b0}}, s};
      2'd2:    return {{W{1'b0}}, p[W-1:0]};
      2'd3:    return p;
      default: return '0;
    endcase
  endfunction

  function automatic bit model_live();
    return mv[0] || mv[1] || mv[2];
  endfunction

  function automatic bit model_ready(logic [1:0] op);
    return !mbusy && (!model_live() || op == 2'd0 || ((op == 2'd3) == mlong));
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) mv[i] = 1'b0;
    mlong = 1'b0; mbusy = 1'b0; exp_we = 1'b0;
  endtask

  task automatic model_fire(logic [1:0] op, logic [W-1:0] x, logic [W-1:0] y, logic [IW-1:0] d);
    int ex;
    bit nl;
    ex = mlong ? 1 : 2;
    exp_we = mv[ex]; exp_idx = d; exp_dat = mr[ex]; exp_long = mlong;
    nl = (op != 2'd0) ? (op == 2'd3) : mlong;
    mv[2] = nl ? 1'b0 : mv[1]; mr[2] = mr[1];
    mv[1] = mv[0];             mr[1] = mr[0];
    mv[0] = (op != 2'd0);      mr[0] = ref_res(op, x, y);
    mlong = nl; mbusy = nl;
  endtask

  // one clock: check last edge's write, drive, check ready, update model
  task automatic step(input bit v, input logic [1:0] op, input logic [W-1:0] x,
                      input logic [W-1:0] y, input logic [IW-1:0] d);
    bit er;
    string rq;
    @(negedge clk);
    // R9: one-cycle strobe right after the accepting edge; R8: empty exit slot writes nothing
    chk(wr_en == exp_we, exp_we ? "R9" : "R8", 64'(wr_en), 64'(exp_we));
    if (exp_we) begin
      chk(wr_idx == exp_idx, exp_long ? "R5" : "R3", 64'(wr_idx), 64'(exp_idx));
      chk(wr_data == exp_dat, "R4", 64'(wr_data), 64'(exp_dat));
    end
    issue_valid = v; issue_op = op; issue_a = x; issue_b = y; issue_dest = d;
    #1;
    er = model_ready(op);
    if (mbusy) rq = "R6";
    else if (!er) rq = "R7";
    else rq = "R10";
    chk(issue_ready == er, rq, 64'(issue_ready), 64'(er));
    if (v && er) model_fire(op, x, y, d);
    else begin
      exp_we = 1'b0; // R2 / R10: nothing moves
      mbusy  = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'($urandom), W'($urandom), W'($urandom), IW'($urandom));
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(wr_en == 1'b0, "R1", 64'(wr_en), 64'd0);
    issue_op = 2'd3; #1;
    chk(issue_ready == 1'b1, "R1", 64'(issue_ready), 64'd1);
    rst = 1'b0;

    // R3 R4 R2: three short ops, long idle, then drain with no-ops
    step(1'b1, 2'd1, 16'd3, 16'd4, 5'd1);
    step(1'b1, 2'd2, 16'd5, 16'd6, 5'd2);
    step(1'b1, 2'd1, 16'hffff, 16'd2, 5'd3);
    idle(8);
    step(1'b1, 2'd0, '0, '0, 5'd7);
    step(1'b1, 2'd0, '0, '0, 5'd8);
    step(1'b1, 2'd0, '0, '0, 5'd9);
    step(1'b1, 2'd0, '0, '0, 5'd10);

    // R7: long op refused while a short op is in flight
    step(1'b1, 2'd2, 16'hff00, 16'h0101, 5'd4);
    step(1'b1, 2'd3, 16'hffff, 16'hffff, 5'd5);
    step(1'b1, 2'd0, '0, '0, 5'd11);
    step(1'b1, 2'd0, '0, '0, 5'd12);
    step(1'b1, 2'd0, '0, '0, 5'd13);

    // R5 R6: back-to-back wide multiplies with stall cycles
    step(1'b1, 2'd3, 16'hffff, 16'hffff, 5'd14);
    step(1'b1, 2'd3, 16'h1234, 16'h5678, 5'd15);
    step(1'b1, 2'd3, 16'h1234, 16'h5678, 5'd15);
    step(1'b1, 2'd1, 16'd1, 16'd1, 5'd16);
    step(1'b1, 2'd0, '0, '0, 5'd17);
    step(1'b1, 2'd0, '0, '0, 5'd18);
    step(1'b1, 2'd0, '0, '0, 5'd19);
    step(1'b1, 2'd0, '0, '0, 5'd20);

    // constrained random mix
    for (int n = 0; n < 3000; n++)
      step(($urandom % 10) < 7, 2'($urandom), W'($urandom), W'($urandom), IW'($urandom));
    for (int n = 0; n < 8; n++) step(1'b1, 2'd0, '0, '0, IW'(n));
    idle(2);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule